// File: doc/BRIEF.md
# DMA Circular Address Generator

This block keeps the running source and destination addresses of one DMA channel. A read-done strobe moves the source address and a write-done strobe moves the destination address. Each step adds that side's own sign-extended 16-bit offset. A power-of-two modulo window can limit a step so that only the low address bits change. This gives a circular buffer without any compare logic.

Two more adjustments sit on top of the per-access step. At the end of a minor loop, each side can add a shared signed minor-loop offset if its own enable is set. At the end of a major loop, each side adds its own signed 32-bit end adjustment. This adjustment replaces both the access step and the minor offset. A load strobe seeds both addresses. Each side also decodes its access-size code into a byte count for the byte lanes of the bus.

Top module: `dma_circ_addr_gen`

## Requirements
- R1: While rst_ni is low, both address outputs are 0.
- R2: When init_i is high, the cycle after the edge shows init_src_addr_i and init_dst_addr_i on the outputs. Every other strobe in that cycle is ignored.
- R3: rd_done_i adds the sign-extended 16-bit src_off_i to the source address. wr_done_i adds dst_off_i to the destination address. Each side moves only on its own strobe, and the new value appears one cycle after the strobe.
- R4: A modulo code of 0 makes the access step a plain 32-bit add that wraps at 2^32.
- R5: A modulo code n from 1 to 31 makes the access step replace only address bits [n-1:0] with the sum. Bits above n-1 keep their value.
- R6: When minor_end_i is high, minor_off_i (signed, 32-bit) is added to each side whose minor enable is high. A side whose enable is low does not change.
- R7: When an access strobe and minor_end_i are high in the same cycle, the access step is taken first, including the modulo. The minor offset is then added to that result as a full-width add that the modulo does not limit.
- R8: When major_end_i is high, each side adds its own signed 32-bit last value with a full-width add. This happens instead of the access step and the minor offset, whatever the other strobes are.
- R9: The byte-count outputs are 2^code for size codes 0 to 6, which gives 1, 2, 4, 8, 16, 32 and 64. Code 7 gives 0. Source and destination decode independently.
- R10: When no strobe applies to a side, its address holds.
- R11: minor_end_i alone adds only the minor offset. No access offset is added.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| init_i | input | 1 | Load both addresses |
| init_src_addr_i | input | 32 | Source seed address |
| init_dst_addr_i | input | 32 | Destination seed address |
| rd_done_i | input | 1 | Source read completed |
| wr_done_i | input | 1 | Destination write completed |
| minor_end_i | input | 1 | Minor loop completed |
| major_end_i | input | 1 | Major loop completed |
| src_off_i | input | 16 | Signed source step |
| dst_off_i | input | 16 | Signed destination step |
| src_mod_i | input | 5 | Source modulo code |
| dst_mod_i | input | 5 | Destination modulo code |
| src_size_i | input | 3 | Source access-size code |
| dst_size_i | input | 3 | Destination access-size code |
| minor_off_i | input | 32 | Signed minor-loop offset |
| src_minor_en_i | input | 1 | Apply minor offset to source |
| dst_minor_en_i | input | 1 | Apply minor offset to destination |
| src_last_i | input | 32 | Signed source end adjustment |
| dst_last_i | input | 32 | Signed destination end adjustment |
| src_addr_o | output | 32 | Current source address |
| dst_addr_o | output | 32 | Current destination address |
| src_bytes_o | output | 7 | Source access byte count |
| dst_bytes_o | output | 7 | Destination access byte count |

## Verification
The assertions assume that the offsets, modulo codes, last values and enables are valid in the same cycle as the strobe that uses them. The properties sample them together with that strobe. The modulo-window property uses only cycles that have an access strobe and no minor or major adjustment. The reason is that those two adjustments may legally move the upper bits. The stimulus changes configuration only at the falling edge and together with the strobes of that cycle. It never leaves a strobe high into a cycle whose configuration it has not set.

// File: rtl/dma_addr_pkg.sv
package dma_addr_pkg;
  typedef enum logic {SIDE_SRC = 1'b0, SIDE_DST = 1'b1} side_e;
  localparam int unsigned NUM_SIDES = 2;

  typedef struct packed {
    logic init;
    logic acc;
    logic minor;
    logic major;
  } strobe_t;
endpackage

// File: rtl/dma_mod_mask.sv
// keep_o marks address bits frozen by the modulo window
module dma_mod_mask #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned MOD_W  = 5
) (
  input  logic [MOD_W-1:0]  mod_i,
  output logic [ADDR_W-1:0] keep_o
);
  logic active;
  assign active = (mod_i != '0);

  for (genvar b = 0; b < ADDR_W; b++) begin : g_bit
    assign keep_o[b] = active && (32'(b) >= 32'(mod_i));
  end
endmodule

// File: rtl/dma_size_dec.sv
module dma_size_dec #(
  parameter int unsigned SIZE_W  = 3,
  parameter int unsigned BYTES_W = 7
) (
  input  logic [SIZE_W-1:0]  size_i,
  output logic [BYTES_W-1:0] bytes_o
);
  for (genvar b = 0; b < BYTES_W; b++) begin : g_code
    assign bytes_o[b] = (32'(size_i) == b);
  end
endmodule

// File: rtl/dma_addr_lane.sv
module dma_addr_lane
  import dma_addr_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFF_W  = 16,
  parameter int unsigned MOFF_W = 32,
  parameter int unsigned MOD_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  strobe_t           stb_i,
  input  logic              minor_en_i,
  input  logic [ADDR_W-1:0] init_addr_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [MOFF_W-1:0] moff_i,
  input  logic [ADDR_W-1:0] last_i,
  input  logic [MOD_W-1:0]  mod_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] addr_q, addr_d, keep, step_sum, stepped, moff_x, off_x;
  logic              upd;

  dma_mod_mask #(.ADDR_W(ADDR_W), .MOD_W(MOD_W)) u_mask (
    .mod_i (mod_i),
    .keep_o(keep)
  );

  assign off_x    = ADDR_W'($signed(off_i));
  assign moff_x   = ADDR_W'($signed(moff_i));
  assign step_sum = addr_q + off_x;

  always_comb begin
    stepped = stb_i.acc ? ((addr_q & keep) | (step_sum & ~keep)) : addr_q;
    if (stb_i.init)       addr_d = init_addr_i;
    else if (stb_i.major) addr_d = addr_q + last_i;
    else if (stb_i.minor && minor_en_i) addr_d = stepped + moff_x;
    else                  addr_d = stepped;
  end

  assign upd = stb_i.init | stb_i.acc | stb_i.minor | stb_i.major;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  addr_q <= '0;
    else if (upd) addr_q <= addr_d;
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/dma_circ_addr_gen.sv
module dma_circ_addr_gen
  import dma_addr_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned OFF_W   = 16,
  parameter int unsigned MOFF_W  = 32,
  parameter int unsigned MOD_W   = 5,
  parameter int unsigned SIZE_W  = 3,
  parameter int unsigned BYTES_W = 7
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               init_i,
  input  logic [ADDR_W-1:0]  init_src_addr_i,
  input  logic [ADDR_W-1:0]  init_dst_addr_i,
  input  logic               rd_done_i,
  input  logic               wr_done_i,
  input  logic               minor_end_i,
  input  logic               major_end_i,
  input  logic [OFF_W-1:0]   src_off_i,
  input  logic [OFF_W-1:0]   dst_off_i,
  input  logic [MOD_W-1:0]   src_mod_i,
  input  logic [MOD_W-1:0]   dst_mod_i,
  input  logic [SIZE_W-1:0]  src_size_i,
  input  logic [SIZE_W-1:0]  dst_size_i,
  input  logic [MOFF_W-1:0]  minor_off_i,
  input  logic               src_minor_en_i,
  input  logic               dst_minor_en_i,
  input  logic [ADDR_W-1:0]  src_last_i,
  input  logic [ADDR_W-1:0]  dst_last_i,
  output logic [ADDR_W-1:0]  src_addr_o,
  output logic [ADDR_W-1:0]  dst_addr_o,
  output logic [BYTES_W-1:0] src_bytes_o,
  output logic [BYTES_W-1:0] dst_bytes_o
);
  localparam int unsigned NS = NUM_SIDES;

  strobe_t            stb   [NS];
  logic               men   [NS];
  logic [ADDR_W-1:0]  init_a[NS];
  logic [OFF_W-1:0]   off   [NS];
  logic [ADDR_W-1:0]  last  [NS];
  logic [MOD_W-1:0]   modc  [NS];
  logic [SIZE_W-1:0]  size  [NS];
  logic [ADDR_W-1:0]  addr  [NS];
  logic [BYTES_W-1:0] bytes [NS];

  always_comb begin
    stb[SIDE_SRC]    = '{init: init_i, acc: rd_done_i, minor: minor_end_i, major: major_end_i};
    stb[SIDE_DST]    = '{init: init_i, acc: wr_done_i, minor: minor_end_i, major: major_end_i};
    men[SIDE_SRC]    = src_minor_en_i;
    men[SIDE_DST]    = dst_minor_en_i;
    init_a[SIDE_SRC] = init_src_addr_i;
    init_a[SIDE_DST] = init_dst_addr_i;
    off[SIDE_SRC]    = src_off_i;
    off[SIDE_DST]    = dst_off_i;
    last[SIDE_SRC]   = src_last_i;
    last[SIDE_DST]   = dst_last_i;
    modc[SIDE_SRC]   = src_mod_i;
    modc[SIDE_DST]   = dst_mod_i;
    size[SIDE_SRC]   = src_size_i;
    size[SIDE_DST]   = dst_size_i;
  end

  for (genvar s = 0; s < NS; s++) begin : g_side
    dma_addr_lane #(
      .ADDR_W(ADDR_W), .OFF_W(OFF_W), .MOFF_W(MOFF_W), .MOD_W(MOD_W)
    ) u_lane (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .stb_i      (stb[s]),
      .minor_en_i (men[s]),
      .init_addr_i(init_a[s]),
      .off_i      (off[s]),
      .moff_i     (minor_off_i),
      .last_i     (last[s]),
      .mod_i      (modc[s]),
      .addr_o     (addr[s])
    );

    dma_size_dec #(.SIZE_W(SIZE_W), .BYTES_W(BYTES_W)) u_size (
      .size_i (size[s]),
      .bytes_o(bytes[s])
    );
  end

  assign src_addr_o  = addr[SIDE_SRC];
  assign dst_addr_o  = addr[SIDE_DST];
  assign src_bytes_o = bytes[SIDE_SRC];
  assign dst_bytes_o = bytes[SIDE_DST];
endmodule

// File: rtl/dma_circ_addr_gen_chk.sv
module dma_circ_addr_gen_chk #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned OFF_W   = 16,
  parameter int unsigned MOFF_W  = 32,
  parameter int unsigned MOD_W   = 5,
  parameter int unsigned SIZE_W  = 3,
  parameter int unsigned BYTES_W = 7
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               init_i,
  input logic [ADDR_W-1:0]  init_src_addr_i,
  input logic [ADDR_W-1:0]  init_dst_addr_i,
  input logic               rd_done_i,
  input logic               wr_done_i,
  input logic               minor_end_i,
  input logic               major_end_i,
  input logic [OFF_W-1:0]   src_off_i,
  input logic [OFF_W-1:0]   dst_off_i,
  input logic [MOD_W-1:0]   src_mod_i,
  input logic [MOD_W-1:0]   dst_mod_i,
  input logic [SIZE_W-1:0]  src_size_i,
  input logic [SIZE_W-1:0]  dst_size_i,
  input logic [MOFF_W-1:0]  minor_off_i,
  input logic               src_minor_en_i,
  input logic               dst_minor_en_i,
  input logic [ADDR_W-1:0]  src_last_i,
  input logic [ADDR_W-1:0]  dst_last_i,
  input logic [ADDR_W-1:0]  src_addr_o,
  input logic [ADDR_W-1:0]  dst_addr_o,
  input logic [BYTES_W-1:0] src_bytes_o,
  input logic [BYTES_W-1:0] dst_bytes_o
);
  logic src_minor, dst_minor;
  assign src_minor = minor_end_i && src_minor_en_i;
  assign dst_minor = minor_end_i && dst_minor_en_i;

  AST_INIT_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> src_addr_o == $past(init_src_addr_i));  // R2
  AST_INIT_DST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> dst_addr_o == $past(init_dst_addr_i));  // R2
  AST_HOLD_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_i && !rd_done_i && !src_minor && !major_end_i) |=> $stable(src_addr_o));  // R10
  AST_HOLD_DST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_i && !wr_done_i && !dst_minor && !major_end_i) |=> $stable(dst_addr_o));  // R10
  AST_MAJOR_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_i && major_end_i) |=> src_addr_o == $past(src_addr_o) + $past(src_last_i));  // R8
  AST_MAJOR_DST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_i && major_end_i) |=> dst_addr_o == $past(dst_addr_o) + $past(dst_last_i));  // R8
  AST_WINDOW_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_i && !major_end_i && !src_minor && rd_done_i && src_mod_i != '0)
    |=> ((src_addr_o ^ $past(src_addr_o)) >> $past(src_mod_i)) == '0);  // R5
  AST_WINDOW_DST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_i && !major_end_i && !dst_minor && wr_done_i && dst_mod_i != '0)
    |=> ((dst_addr_o ^ $past(dst_addr_o)) >> $past(dst_mod_i)) == '0);  // R5
  AST_MINOR_ONLY_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_i && !major_end_i && !rd_done_i && src_minor)
    |=> src_addr_o == $past(src_addr_o) + ADDR_W'($signed($past(minor_off_i))));  // R11
  AST_BYTES_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(src_size_i) < BYTES_W) |-> $onehot(src_bytes_o));  // R9
  AST_BYTES_DST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(dst_size_i) >= BYTES_W) |-> dst_bytes_o == '0);  // R9
endmodule

bind dma_circ_addr_gen dma_circ_addr_gen_chk #(
  .ADDR_W(ADDR_W), .OFF_W(OFF_W), .MOFF_W(MOFF_W),
  .MOD_W(MOD_W), .SIZE_W(SIZE_W), .BYTES_W(BYTES_W)
) u_chk (.*);

// File: tb/dma_circ_addr_gen_bench.sv
module dma_circ_addr_gen_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        init_i = 0, rd_done_i = 0, wr_done_i = 0, minor_end_i = 0, major_end_i = 0;
  logic [31:0] init_src_addr_i = 0, init_dst_addr_i = 0;
  logic [15:0] src_off_i = 0, dst_off_i = 0;
  logic [4:0]  src_mod_i = 0, dst_mod_i = 0;
  logic [2:0]  src_size_i = 0, dst_size_i = 0;
  logic [31:0] minor_off_i = 0;
  logic        src_minor_en_i = 0, dst_minor_en_i = 0;
  logic [31:0] src_last_i = 0, dst_last_i = 0;
  logic [31:0] src_addr_o, dst_addr_o;
  logic [6:0]  src_bytes_o, dst_bytes_o;

  int total = 0;
  int bad = 0;
  bit stim_done = 0;

  typedef struct {
    logic [31:0] es;
    logic [31:0] ed;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  logic [31:0] m_src = 0, m_dst = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  dma_circ_addr_gen u_dma_circ_addr_gen (.*);

  function automatic logic [31:0] access_step(logic [31:0] a, logic [15:0] off, logic [4:0] m);
    longint unsigned win, sum, base;
    sum = 64'(a) + 64'(unsigned'(32'($signed(off))));
    if (m == 0) return sum[31:0];
    win  = 64'd1 << m;
    base = 64'(a) - (64'(a) % win);
    return 32'(base + (sum % win));
  endfunction

  function automatic logic [31:0] side_next(logic [31:0] a, bit ini, logic [31:0] ia, bit acc,
                                            logic [15:0] off, logic [4:0] m, bit mn, bit en,
                                            bit mj, logic [31:0] last);
    logic [31:0] r;
    if (ini) return ia;
    if (mj) return a + last;
    r = acc ? access_step(a, off, m) : a;
    if (mn && en) r = r + minor_off_i;
    return r;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: applies one cycle of strobes, pushes the expected post-edge addresses
  task automatic drive(bit ini, bit rd, bit wr, bit mn, bit mj, string tag);
    exp_t e;
    init_i = ini; rd_done_i = rd; wr_done_i = wr; minor_end_i = mn; major_end_i = mj;
    m_src = side_next(m_src, ini, init_src_addr_i, rd, src_off_i, src_mod_i, mn, src_minor_en_i, mj, src_last_i);
    m_dst = side_next(m_dst, ini, init_dst_addr_i, wr, dst_off_i, dst_mod_i, mn, dst_minor_en_i, mj, dst_last_i);
    e.es = m_src; e.ed = m_dst; e.tag = tag;
    sb_q.push_back(e);
    @(negedge clk_i);
    init_i = 0; rd_done_i = 0; wr_done_i = 0; minor_end_i = 0; major_end_i = 0;
  endtask

  // monitor: compares after each edge
  initial begin
    forever begin
      @(posedge clk_i);
      #1;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        check({e.tag, " src"}, src_addr_o, e.es);
        check({e.tag, " dst"}, dst_addr_o, e.ed);
      end
    end
  end

  task automatic check_bytes(logic [2:0] sc, logic [2:0] dc, logic [6:0] es, logic [6:0] ed);
    src_size_i = sc; dst_size_i = dc;
    #1;
    check("R9 src bytes", {25'b0, src_bytes_o}, {25'b0, es});
    check("R9 dst bytes", {25'b0, dst_bytes_o}, {25'b0, ed});
  endtask

  initial begin
    #(CLK_PERIOD * 3 + 2);
    check("R1 reset src", src_addr_o, 32'h0);
    check("R1 reset dst", dst_addr_o, 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    init_src_addr_i = 32'h1000_0000; init_dst_addr_i = 32'h2000_0100;
    drive(1, 0, 0, 0, 0, "R2 init");
    src_off_i = 16'd4; dst_off_i = 16'h0010;
    drive(0, 1, 0, 0, 0, "R3 rd plus");
    src_off_i = 16'hFFFE;
    drive(0, 1, 0, 0, 0, "R3 rd minus");
    drive(0, 0, 1, 0, 0, "R3 wr only");
    drive(0, 0, 0, 0, 0, "R10 hold");

    init_src_addr_i = 32'h1000_000C; init_dst_addr_i = 32'hFFFF_FFFC;
    drive(1, 1, 1, 1, 1, "R2 init overrides");
    src_mod_i = 5'd4; src_off_i = 16'd8; dst_off_i = 16'd8;
    drive(0, 1, 1, 0, 0, "R5 mod4 / R4 wrap 32");

    init_src_addr_i = 32'hFFFF_FFFE;
    drive(1, 0, 0, 0, 0, "R2 reseed");
    src_mod_i = 5'd31; src_off_i = 16'd4;
    drive(0, 1, 0, 0, 0, "R5 mod31");

    src_mod_i = 5'd0; minor_off_i = 32'h0000_0100;
    src_minor_en_i = 1; dst_minor_en_i = 0;
    drive(0, 0, 0, 1, 0, "R11 R6 minor only");
    minor_off_i = 32'hFFFF_FF00; dst_minor_en_i = 1;
    drive(0, 0, 0, 1, 0, "R6 minor negative");

    init_src_addr_i = 32'h1000_000C; init_dst_addr_i = 32'h3000_0000;
    drive(1, 0, 0, 0, 0, "R2 reseed2");
    src_mod_i = 5'd4; src_off_i = 16'd8; minor_off_i = 32'h20; dst_minor_en_i = 0;
    drive(0, 1, 1, 1, 0, "R7 access then minor");

    src_last_i = 32'hFFFF_FFC0; dst_last_i = 32'h0000_1000; dst_minor_en_i = 1;
    drive(0, 1, 1, 1, 1, "R8 major replaces");
    drive(0, 0, 0, 0, 1, "R8 major alone");
    drive(0, 0, 0, 0, 0, "R10 hold2");

    @(negedge clk_i);
    check_bytes(3'd0, 3'd6, 7'd1, 7'd64);
    check_bytes(3'd3, 3'd7, 7'd8, 7'd0);
    check_bytes(3'd7, 3'd2, 7'd0, 7'd4);

    repeat (3) @(negedge clk_i);
    stim_done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!stim_done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule